// File: doc/BRIEF.md
# Periodic-interrupt real-time clock with index/data register access

This block is a small real-time clock for a system I/O space. Software reaches it through two byte-wide ports. A write to the index port picks one internal register. Later reads and writes on the data port then reach that register. Behind the index are seven calendar fields and four control registers:

- The calendar fields are seconds, minutes, hours, day of week, day of month, month and year.
- The control registers accept writes and discard them.
- The month is held zero-based inside the block. It is converted on every write and on every read.

A periodic tick input raises a one-cycle interrupt pulse on every tick. A ten-bit tick counter makes the seconds field step once every 1024 ticks. The seconds field wraps at 60 and does not carry into the minutes field. Every other calendar field is a plain loadable register.

Bus accesses are handled by a response state machine that registers its result. It has three states:

| State | Meaning |
|-------|---------|
| RESP_IDLE | No access in the previous cycle. |
| RESP_OK | The previous access was accepted. |
| RESP_ERR | The previous access named an unimplemented index. |

Its transitions, taken at every clock edge:

- **go_ok**: any index-port access, or a data-port access to a valid index.
- **go_err**: a data-port access to an unimplemented index.
- **go_idle**: no access this cycle.

Every state can take all three transitions. Read data is registered on the same edge and then holds until the next read.

Top module: `rtc_idx_clock`

## Requirements
- R1: After reset the tick counter, all calendar fields, `bus_rdata`, `irq_pulse` and `acc_err` are zero. A data read of the month index 0x08 then returns 0x01.
- R2: A write to address 0x70 loads the register index from `bus_wdata`. A read of address 0x70 returns the current index on `bus_rdata` one cycle later.
- R3: `irq_pulse` is high for exactly the one cycle after each cycle in which `tick_in` is high, and is low otherwise.
- R4: A tick that arrives while the tick counter is at 1023 advances the seconds field and returns the counter to 0. Other ticks only increment the counter, and the seconds field does not move.
- R5: When the seconds field holds 59 or any larger value, an advance sets it to 0. Otherwise an advance adds 1. The minutes field is never changed by an advance.
- R6: A data-port read returns the selected field on `bus_rdata` in the next cycle, and the value holds until the next read. The field indices are:

  | Index | Field |
  |-------|-------|
  | 0x00 | seconds |
  | 0x02 | minutes |
  | 0x04 | hours |
  | 0x06 | day of week |
  | 0x07 | day of month |
  | 0x09 | year |

  A data-port write to any of these stores the byte. Index 0x07 returns the day of month only, never the month.
- R7: The month at index 0x08 is stored as the written value minus one and is read back as the stored value plus one, both modulo 256. Writing 0x00 therefore reads back as 0x00.
- R8: Control indices 0x0A to 0x0D accept data writes without error, and the writes change no field. Reads of these indices return 0x00.
- R9: A data-port read or write at any other index raises `acc_err` for one cycle and changes no field. Such a read returns 0xFF.
- R10: If a data write to the seconds index falls in the same cycle as a seconds advance, the written value is kept and the advance is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | I/O address: 0x70 is the index port, 0x71 is the data port |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| tick_in | input | 1 | Periodic tick, one cycle per tick |
| bus_rdata | output | 8 | Read data, valid from the cycle after a read |
| irq_pulse | output | 1 | Periodic interrupt pulse |
| acc_err | output | 1 | Unimplemented-index access flag, one-cycle pulse |

## Verification
A seconds write from software and the automatic seconds advance can fall on the same clock edge. The advance happens when the 1024th tick arrives with the counter at 1023. To provoke the overlap, the bench tracks the counter and runs ticks until the counter reaches 1023. It then issues the data write to the seconds index in the same cycle as the next tick, and later reads the field back, expecting the written value rather than the stepped one. The random phase also mixes ticks with data-port traffic to every index, so an interrupt pulse and an error pulse often land in the same cycle, and both are checked on every step.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NFIELDS = 7;

    typedef enum logic [3:0] {
        FLD_SEC  = 4'd0,
        FLD_MIN  = 4'd1,
        FLD_HOUR = 4'd2,
        FLD_DOW  = 4'd3,
        FLD_DOM  = 4'd4,
        FLD_MON  = 4'd5,
        FLD_YEAR = 4'd6,
        FLD_CTRL = 4'd7,
        FLD_NONE = 4'd8
    } field_t;

    typedef enum logic [1:0] {
        RESP_IDLE = 2'd0,
        RESP_OK   = 2'd1,
        RESP_ERR  = 2'd2
    } resp_t;

    // Maps a register index to the field it reaches.
    function automatic field_t decode_index(input logic [7:0] idx);
        field_t f;
        case (idx)
            8'h00:   f = FLD_SEC;
            8'h02:   f = FLD_MIN;
            8'h04:   f = FLD_HOUR;
            8'h06:   f = FLD_DOW;
            8'h07:   f = FLD_DOM;
            8'h08:   f = FLD_MON;
            8'h09:   f = FLD_YEAR;
            8'h0A,
            8'h0B,
            8'h0C,
            8'h0D:   f = FLD_CTRL;
            default: f = FLD_NONE;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int TICKS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic roll,
    output logic irq_pulse
);
    localparam int CW = $clog2(TICKS);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          irq_q;

    assign roll      = tick_in && (cnt_q == LAST);
    assign irq_pulse = irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= tick_in;
            if (tick_in) begin
                if (cnt_q == LAST) cnt_q <= '0;
                else               cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3
    irq_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_in |=> irq_pulse);
    // R3
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_in |=> !irq_pulse);
    // R4
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> (cnt_q == '0));
    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_in |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int W        = 8,
    parameter int SEC_WRAP = 60
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  field_t       wr_fld,
    input  logic [W-1:0] wr_data,
    input  logic         sec_step,
    input  field_t       rd_fld,
    output logic [W-1:0] rd_val
);
    localparam logic [W-1:0] SEC_TOP = W'(SEC_WRAP - 1);

    logic [W-1:0] fld_q [NFIELDS];
    logic         sec_wr;

    assign sec_wr = wr_en && (wr_fld == FLD_SEC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NFIELDS; i++) fld_q[i] <= '0;
        end else begin
            for (int i = 0; i < NFIELDS; i++) begin
                if (wr_en && (int'(wr_fld) == i)) begin
                    if (i == int'(FLD_MON)) fld_q[i] <= wr_data - 1'b1;
                    else                    fld_q[i] <= wr_data;
                end else if ((i == int'(FLD_SEC)) && sec_step) begin
                    if (fld_q[i] >= SEC_TOP) fld_q[i] <= '0;
                    else                     fld_q[i] <= fld_q[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NFIELDS; i++) begin
            if (int'(rd_fld) == i) rd_val = fld_q[i];
        end
        if (rd_fld == FLD_MON) rd_val = fld_q[int'(FLD_MON)] + 1'b1;
    end

    // R5
    sec_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_step && !sec_wr) |=>
        (fld_q[0] == (($past(fld_q[0]) >= SEC_TOP) ? '0 : $past(fld_q[0]) + 1'b1)));
    // R5
    min_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_step && !(wr_en && wr_fld == FLD_MIN)) |=> $stable(fld_q[1]));
    // R10
    sec_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr |=> (fld_q[0] == $past(wr_data)));
    // R7
    mon_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fld == FLD_MON) |=> (fld_q[5] == $past(wr_data) - 1'b1));

endmodule

// File: rtl/rtc_port_fsm.sv
module rtc_port_fsm
    import rtc_pkg::*;
#(
    parameter logic [7:0] IDX_ADDR  = 8'h70,
    parameter logic [7:0] DATA_ADDR = 8'h71
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    input  logic [7:0] rd_val,
    output logic       cal_wr,
    output field_t     cal_fld,
    output logic [7:0] bus_rdata,
    output logic       acc_err
);
    logic [7:0] index_q;
    logic [7:0] rdata_q;
    resp_t      resp_q, resp_d;
    field_t     fld;
    logic       idx_wr, idx_rd, data_wr, data_rd, data_acc;

    assign fld      = decode_index(index_q);
    assign idx_wr   = bus_wr && (bus_addr == IDX_ADDR);
    assign idx_rd   = bus_rd && (bus_addr == IDX_ADDR);
    assign data_wr  = bus_wr && (bus_addr == DATA_ADDR);
    assign data_rd  = bus_rd && (bus_addr == DATA_ADDR);
    assign data_acc = data_wr || data_rd;

    assign cal_fld  = fld;
    assign cal_wr   = data_wr && (fld != FLD_CTRL) && (fld != FLD_NONE);

    // Next-state logic
    always_comb begin
        if (data_acc && (fld == FLD_NONE))   resp_d = RESP_ERR;
        else if (data_acc || idx_wr || idx_rd) resp_d = RESP_OK;
        else                                 resp_d = RESP_IDLE;
    end

    // State register, index register and read-data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q  <= RESP_IDLE;
            index_q <= '0;
            rdata_q <= '0;
        end else begin
            resp_q <= resp_d;
            if (idx_wr) index_q <= bus_wdata;
            if (idx_rd) begin
                rdata_q <= index_q;
            end else if (data_rd) begin
                unique case (fld)
                    FLD_NONE: rdata_q <= 8'hFF;
                    FLD_CTRL: rdata_q <= 8'h00;
                    default:  rdata_q <= rd_val;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (resp_q)
            RESP_ERR: acc_err = 1'b1;
            default:  acc_err = 1'b0;
        endcase
    end
    assign bus_rdata = rdata_q;

    // R2
    index_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (index_q == $past(bus_wdata)));
    // R9
    bad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && fld == FLD_NONE) |=> (acc_err && bus_rdata == 8'hFF));
    // R9
    bad_write_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fld == FLD_NONE) |-> !cal_wr);
    // R8
    ctrl_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !data_rd && fld == FLD_CTRL) |=> !acc_err);
    // R8
    ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && fld == FLD_CTRL) |=> (bus_rdata == 8'h00));

endmodule

// File: rtl/rtc_idx_clock.sv
module rtc_idx_clock
    import rtc_pkg::*;
#(
    parameter logic [7:0] IDX_ADDR  = 8'h70,
    parameter logic [7:0] DATA_ADDR = 8'h71,
    parameter int         TICKS     = 1024,
    parameter int         SEC_WRAP  = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    input  logic       tick_in,
    output logic [7:0] bus_rdata,
    output logic       irq_pulse,
    output logic       acc_err
);
    logic       roll;
    logic       cal_wr;
    field_t     cal_fld;
    logic [7:0] rd_val;

    rtc_tick_div #(.TICKS(TICKS)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick_in),
        .roll      (roll),
        .irq_pulse (irq_pulse)
    );

    rtc_calendar #(.W(8), .SEC_WRAP(SEC_WRAP)) u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cal_wr),
        .wr_fld   (cal_fld),
        .wr_data  (bus_wdata),
        .sec_step (roll),
        .rd_fld   (cal_fld),
        .rd_val   (rd_val)
    );

    rtc_port_fsm #(.IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .rd_val    (rd_val),
        .cal_wr    (cal_wr),
        .cal_fld   (cal_fld),
        .bus_rdata (bus_rdata),
        .acc_err   (acc_err)
    );

    // R1
    reset_outputs_chk: assert property (@(posedge clk)
        !rst_n |=> (bus_rdata == 8'h00 && !irq_pulse && !acc_err));

endmodule

// File: tb/rtc_idx_clock_bench.sv
`timescale 1ns/1ps
module rtc_idx_clock_bench;
    localparam logic [7:0] IA = 8'h70;
    localparam logic [7:0] DA = 8'h71;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       tick_in = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq_pulse;
    logic       acc_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_idx = '0;
    int         m_cnt = 0;
    logic [7:0] m_f [7];
    logic [7:0] m_rdata = '0;

    always #2 clk = ~clk;

    rtc_idx_clock u_rtc_idx_clock (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .tick_in(tick_in),
        .bus_rdata(bus_rdata), .irq_pulse(irq_pulse), .acc_err(acc_err)
    );

    // Field slot of an index: 0..6 calendar, 7 control, 8 unimplemented
    function automatic int slot_of(input logic [7:0] idx);
        case (idx)
            8'h00: return 0;
            8'h02: return 1;
            8'h04: return 2;
            8'h06: return 3;
            8'h07: return 4;
            8'h08: return 5;
            8'h09: return 6;
            8'h0A, 8'h0B, 8'h0C, 8'h0D: return 7;
            default: return 8;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] idx);
        int s;
        s = slot_of(idx);
        if (s == 8) return 8'hFF;
        if (s == 7) return 8'h00;
        if (s == 5) return m_f[5] + 8'd1;
        return m_f[s];
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic rd, input logic wr,
                        input logic [7:0] a, input logic [7:0] d, input string tag);
        int  s;
        bit  roll;
        logic e_err;
        tick_in = t; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        s = slot_of(m_idx);
        e_err = (rd || wr) && (a == DA) && (s == 8);
        if (rd && a == IA) m_rdata = m_idx;
        else if (rd && a == DA) m_rdata = exp_read(m_idx);
        roll = t && (m_cnt == 1023);
        if (t) m_cnt = (m_cnt + 1) % 1024;
        if (roll) m_f[0] = (m_f[0] >= 8'd59) ? 8'd0 : m_f[0] + 8'd1;
        if (wr && a == DA && s < 7) m_f[s] = (s == 5) ? d - 8'd1 : d;
        if (wr && a == IA) m_idx = d;
        #1;
        tick_in = 0; bus_rd = 0; bus_wr = 0;
        chk("R3 irq", {7'd0, irq_pulse}, {7'd0, t});
        chk("R9 err", {7'd0, acc_err}, {7'd0, e_err});
        if (rd) chk(tag, bus_rdata, m_rdata);
    endtask

    task automatic wr_idx(input logic [7:0] i); step(0, 0, 1, IA, i, "R2"); endtask
    task automatic wr_dat(input logic [7:0] d); step(0, 0, 1, DA, d, "R6"); endtask
    task automatic rd_dat(input string tag);    step(0, 1, 0, DA, 8'h00, tag); endtask
    task automatic tick_to_last();
        while (m_cnt != 1023) step(1, 0, 0, 8'h00, 8'h00, "R4");
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] idxs [10];
        int seed;
        for (int i = 0; i < 7; i++) m_f[i] = 8'h00;
        idxs = '{8'h00, 8'h02, 8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0B, 8'h01, 8'h3F};
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 irq", {7'd0, irq_pulse}, 8'h00);
        chk("R1 err", {7'd0, acc_err}, 8'h00);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: fields zero, month reads one
        wr_idx(8'h08); rd_dat("R1 month"); chk("R1 month", bus_rdata, 8'h01);
        wr_idx(8'h00); rd_dat("R1 sec");   chk("R1 sec", bus_rdata, 8'h00);

        // R2: index read back
        wr_idx(8'h07); step(0, 1, 0, IA, 8'h00, "R2"); chk("R2", bus_rdata, 8'h07);

        // R6: load every field, read back, day of month versus month
        for (int i = 0; i < 7; i++) begin
            wr_idx(idxs[i]); wr_dat(8'h11 * (i + 1));
        end
        for (int i = 0; i < 7; i++) begin
            wr_idx(idxs[i]); rd_dat("R6");
        end
        wr_idx(8'h07); rd_dat("R6 dom"); chk("R6 dom", bus_rdata, 8'h55);
        step(0, 0, 0, 8'h00, 8'h00, "R6"); chk("R6 hold", bus_rdata, 8'h55);

        // R7: month offset
        wr_idx(8'h08); wr_dat(8'h0C); rd_dat("R7"); chk("R7", bus_rdata, 8'h0C);
        wr_dat(8'h00); rd_dat("R7 zero"); chk("R7 zero", bus_rdata, 8'h00);

        // R8: control writes discarded, reads zero
        for (int c = 10; c < 14; c++) begin
            wr_idx(8'(c)); wr_dat(8'hA5); rd_dat("R8"); chk("R8", bus_rdata, 8'h00);
        end
        for (int i = 0; i < 7; i++) begin wr_idx(idxs[i]); rd_dat("R8 fields"); end

        // R9: unimplemented index
        wr_idx(8'h01); rd_dat("R9"); chk("R9 rd", bus_rdata, 8'hFF);
        wr_dat(8'h3C);
        wr_idx(8'h02); rd_dat("R9 nochange"); chk("R9 nochange", bus_rdata, 8'h22);

        // R4: advance after 1024 ticks
        wr_idx(8'h00); wr_dat(8'h00);
        tick_to_last();
        rd_dat("R4 before"); chk("R4 before", bus_rdata, 8'h00);
        step(1, 0, 0, 8'h00, 8'h00, "R4");
        rd_dat("R4 after"); chk("R4 after", bus_rdata, 8'h01);

        // R5: wrap from 59 and from an out-of-range value, no carry
        wr_dat(8'd59); tick_to_last(); step(1, 0, 0, 8'h00, 8'h00, "R5");
        rd_dat("R5 wrap"); chk("R5 wrap", bus_rdata, 8'h00);
        wr_dat(8'd75); tick_to_last(); step(1, 0, 0, 8'h00, 8'h00, "R5");
        rd_dat("R5 big"); chk("R5 big", bus_rdata, 8'h00);
        wr_idx(8'h02); rd_dat("R5 min"); chk("R5 min", bus_rdata, 8'h22);

        // R10: seconds write on the advancing tick
        wr_idx(8'h00); wr_dat(8'd10); tick_to_last();
        step(1, 0, 1, DA, 8'd30, "R10");
        rd_dat("R10"); chk("R10", bus_rdata, 8'd30);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int k;
            logic t;
            t = ($urandom % 3) == 0;
            k = $urandom % 6;
            case (k)
                0: step(t, 0, 1, IA, idxs[$urandom % 10], "R2");
                1: step(t, 0, 1, DA, 8'($urandom), "R6");
                2, 3: step(t, 1, 0, DA, 8'h00, "R6");
                4: step(t, 1, 0, IA, 8'h00, "R2");
                default: step(t, 0, 0, 8'h72, 8'h00, "R3");
            endcase
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule